// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Bank Tracker

This block follows the registered command stream of a synchronous DRAM, one cycle at a time, and keeps a state machine for every bank. It can sit next to a memory controller as a protocol monitor, or inside a synthesizable device model. Each cycle it takes a command code, a bank number, an auto-precharge flag and the DQM input. From these it works out each bank's state, the cycles in which read data is driven, and an error strobe for protocol violations.

Auto-precharge does not block traffic to other banks. A READ or WRITE that goes to a different bank cuts short a read or write burst that is still running. If that cut burst carried auto-precharge, its bank starts precharging in the cycle the interrupting command is registered. A READ that interrupts lets the new bank's data follow one CAS latency later, with no gap. A WRITE that interrupts removes every read beat still in flight. The controller must raise DQM two clocks before that WRITE, so that the last read beat cannot collide with the first write beat.

Each bank machine has six states and these transitions:
- IDLE goes to ACTIVE on ACTIVATE.
- ACTIVE goes to RD_BURST on READ, to WR_BURST on WRITE, and to PRECHG on PRECHARGE.
- A burst ends after BL cycles, or earlier when an access to another bank interrupts it. A burst without auto-precharge then goes back to ACTIVE. A read burst with auto-precharge goes to PRECHG. A write burst with auto-precharge goes to WR_RECOV.
- WR_RECOV goes to PRECHG after TWR cycles.
- PRECHG goes to IDLE after TRP cycles. An ACTIVATE in the last cycle of PRECHG goes straight to ACTIVE.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, or whenever `rst_n` is low at a clock edge, every bank reads IDLE, and `rd_drive_o` and `err_o` are low. The 3-bit state codes are IDLE=0, ACTIVE=1, RD_BURST=2, WR_BURST=3, WR_RECOV=4 and PRECHG=5. Bank i sits at `bank_state_o[3i+2:3i]`.
- R2: The command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4 and DESELECT=7. ACTIVATE takes an IDLE bank to ACTIVE. PRECHARGE takes an open bank to PRECHG. The bank reads PRECHG for TRP cycles and then IDLE. An ACTIVATE registered TRP clocks after the PRECHARGE is accepted.
- R3: A READ or WRITE without auto-precharge (`ap_i`=0) holds the bank in RD_BURST or WR_BURST for BL cycles. The bank then returns to ACTIVE. It also returns to ACTIVE at once when an access to another bank interrupts the burst.
- R4: Each issued read beat raises `rd_drive_o` in the cycle that ends CL clocks after the beat was issued. A READ to an open bank issues BL beats on consecutive cycles.
- R5: A READ to bank m that interrupts an auto-precharge read on bank n moves bank n to PRECHG in the cycle the READ is registered. Bank m's beats follow without a gap. A new ACTIVATE to bank n is accepted TRP clocks after the interrupting READ.
- R6: A WRITE to an open bank stops any read burst. All read beats still in flight are discarded, so `rd_drive_o` is low from the cycle after the WRITE. An interrupted auto-precharge read bank goes to PRECHG in that same cycle.
- R7: A read beat whose drive cycle is the second cycle after DQM was sampled high is suppressed.
- R8: A WRITE registered while `rd_drive_o` is high (DQM was low two clocks earlier) raises `err_o` for one cycle.
- R9: An auto-precharge write holds WR_BURST for BL cycles, then WR_RECOV for TWR cycles, then PRECHG for TRP cycles, and then becomes IDLE.
- R10: A READ or WRITE to a bank that is not ACTIVE, RD_BURST or WR_BURST raises `err_o` in the next cycle. It is otherwise ignored: no beats are issued and no bank changes state.
- R11: An ACTIVATE to a bank that is neither IDLE nor in its last PRECHG cycle raises `err_o` in the next cycle. The bank's state and timer are left unchanged.
- R12: NOP, DESELECT and the unused codes only advance the timers and the burst position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Registered command code |
| bank_i | input | BANK_W | Bank the command targets |
| ap_i | input | 1 | Auto-precharge flag for READ/WRITE |
| dqm_i | input | 1 | Data mask input |
| rd_drive_o | output | 1 | High in cycles where a read beat is driven |
| err_o | output | 1 | Protocol error strobe, one cycle after the offending command |
| bank_state_o | output | 3*NBANK | Packed per-bank state codes |

## Verification
The bench goes after the instant at which precharge begins for an interrupted auto-precharge read. It does this by sending an ACTIVATE exactly TRP clocks after the interrupting READ. A design that waited for the natural end of the burst would flag that ACTIVATE as an error. For the write interrupt, it checks that the beats in flight vanish and that DQM placed two clocks ahead clears the error. A design with the wrong DQM latency, or one that fails to flush, would show a stray drive cycle or an error at the write. The bench also checks the write-recovery chain and the boundary cycles of each timer. It checks that illegal accesses change no state and issue no beats, by watching the drive output through the cycle where those beats would have appeared.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_RD    = 3'd2,
        CMD_WR    = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_DESEL = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_ACTIVE  = 3'd1,
        BK_RDBURST = 3'd2,
        BK_WRBURST = 3'd3,
        BK_WRRECOV = 3'd4,
        BK_PRECHG  = 3'd5
    } bank_st_e;

endpackage

// File: rtl/sdtrk_bank_fsm.sv
module sdtrk_bank_fsm
    import sdtrk_pkg::*;
#(
    parameter int BL  = 4,
    parameter int TRP = 3,
    parameter int TWR = 2,
    parameter int CW  = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     cmd,
    input  logic     hit,
    input  logic     ap,
    input  logic     other_acc,
    output bank_st_e st_o,
    output logic     acc_ok_o,
    output logic     err_o
);

    bank_st_e       st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           ap_q, ap_n;
    logic           is_acc, is_act, act_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= BK_IDLE;
            cnt  <= '0;
            ap_q <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            ap_q <= ap_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = (cnt != '0) ? cnt - 1'b1 : '0;
        ap_n  = ap_q;
        unique case (st)
            BK_IDLE: begin
                if (hit && cmd == CMD_ACT) st_n = BK_ACTIVE;
            end
            BK_ACTIVE, BK_RDBURST, BK_WRBURST: begin
                if ((st != BK_ACTIVE) && (other_acc || cnt == '0)) begin
                    if (!ap_q) begin
                        st_n = BK_ACTIVE;
                    end else if (st == BK_WRBURST) begin
                        st_n  = BK_WRRECOV;
                        cnt_n = CW'(TWR - 1);
                    end else begin
                        st_n  = BK_PRECHG;
                        cnt_n = CW'(TRP - 1);
                    end
                end
                if (hit && cmd == CMD_RD) begin
                    st_n  = BK_RDBURST;
                    cnt_n = CW'(BL - 1);
                    ap_n  = ap;
                end else if (hit && cmd == CMD_WR) begin
                    st_n  = BK_WRBURST;
                    cnt_n = CW'(BL - 1);
                    ap_n  = ap;
                end else if (hit && cmd == CMD_PRE) begin
                    st_n  = BK_PRECHG;
                    cnt_n = CW'(TRP - 1);
                end
            end
            BK_WRRECOV: begin
                if (cnt == '0) begin
                    st_n  = BK_PRECHG;
                    cnt_n = CW'(TRP - 1);
                end
            end
            BK_PRECHG: begin
                if (cnt == '0)
                    st_n = (hit && cmd == CMD_ACT) ? BK_ACTIVE : BK_IDLE;
            end
            default: st_n = BK_IDLE;
        endcase
    end

    always_comb begin
        is_acc   = (cmd == CMD_RD) || (cmd == CMD_WR);
        is_act   = (cmd == CMD_ACT);
        acc_ok_o = (st == BK_ACTIVE) || (st == BK_RDBURST) || (st == BK_WRBURST);
        act_ok   = (st == BK_IDLE) || (st == BK_PRECHG && cnt == '0);
        err_o    = hit && ((is_acc && !acc_ok_o) || (is_act && !act_ok));
        st_o     = st;
    end

endmodule

// File: rtl/sdtrk_read_pipe.sv
module sdtrk_read_pipe #(
    parameter int BL = 4,
    parameter int CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_go,
    input  logic wr_go,
    input  logic dqm,
    output logic drive_o,
    output logic collide_o
);

    localparam int RW = $clog2(BL) + 1;

    logic [CL-1:0] sr;
    logic [1:0]    dq;
    logic [RW-1:0] rem;
    logic          issue;

    always_comb begin
        issue     = rd_go || ((rem != '0) && !wr_go);
        drive_o   = sr[CL-1] && !dq[1];
        collide_o = wr_go && drive_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            dq  <= '0;
            rem <= '0;
        end else begin
            dq <= {dq[0], dqm};
            if (wr_go) sr <= '0;
            else       sr <= {sr[CL-2:0], issue};
            if (rd_go)           rem <= RW'(BL - 1);
            else if (wr_go)      rem <= '0;
            else if (rem != '0)  rem <= rem - 1'b1;
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdtrk_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BL    = 4,
    parameter int CL    = 3,
    parameter int TRP   = 3,
    parameter int TWR   = 2,
    localparam int BANK_W = $clog2(NBANK),
    localparam int TMAX   = (BL > TRP) ? ((BL > TWR) ? BL : TWR) : ((TRP > TWR) ? TRP : TWR),
    localparam int CW     = $clog2(TMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 ap_i,
    input  logic                 dqm_i,
    output logic                 rd_drive_o,
    output logic                 err_o,
    output logic [3*NBANK-1:0]   bank_state_o
);

    cmd_e             cmd;
    logic [NBANK-1:0] acc_ok;
    logic [NBANK-1:0] bank_err;
    logic [NBANK-1:0] hit;
    logic             acc_go, rd_go, wr_go, collide, err_q;

    assign cmd = cmd_e'(cmd_i);

    always_comb begin
        acc_go = ((cmd == CMD_RD) || (cmd == CMD_WR)) && acc_ok[bank_i];
        rd_go  = (cmd == CMD_RD) && acc_ok[bank_i];
        wr_go  = (cmd == CMD_WR) && acc_ok[bank_i];
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        bank_st_e st;
        assign hit[i] = (bank_i == BANK_W'(i));
        sdtrk_bank_fsm #(.BL(BL), .TRP(TRP), .TWR(TWR), .CW(CW)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd),
            .hit       (hit[i]),
            .ap        (ap_i),
            .other_acc (acc_go && !hit[i]),
            .st_o      (st),
            .acc_ok_o  (acc_ok[i]),
            .err_o     (bank_err[i])
        );
        assign bank_state_o[3*i +: 3] = st;
    end

    sdtrk_read_pipe #(.BL(BL), .CL(CL)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .dqm       (dqm_i),
        .drive_o   (rd_drive_o),
        .collide_o (collide)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (|bank_err) || collide;
    end

    assign err_o = err_q;

endmodule

// File: rtl/sdtrk_chk.sv
module sdtrk_chk #(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cmd_i,
    input logic [BANK_W-1:0]  bank_i,
    input logic               dqm_i,
    input logic               rd_drive_o,
    input logic               err_o,
    input logic [3*NBANK-1:0] bank_state_o,
    input logic [NBANK-1:0]   acc_ok
);

    logic [2:0] sel;
    assign sel = bank_state_o[3*bank_i +: 3];

    AST_IDLE_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 3'd2 || cmd_i == 3'd3) && sel == 3'd0) |=> err_o); // R10

    AST_ACT_OPEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && sel == 3'd1) |=> err_o); // R11

    AST_WR_COLLIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd3 && rd_drive_o) |=> err_o); // R8

    AST_WR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd3 && acc_ok[bank_i]) |=> !rd_drive_o); // R6

    AST_DQM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        dqm_i |=> ##1 !rd_drive_o); // R7

endmodule

bind sdram_bank_tracker sdtrk_chk #(.NBANK(NBANK), .BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .bank_i       (bank_i),
    .dqm_i        (dqm_i),
    .rd_drive_o   (rd_drive_o),
    .err_o        (err_o),
    .bank_state_o (bank_state_o),
    .acc_ok       (acc_ok)
);

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd0;
    logic [1:0]  bank_i = 2'd0;
    logic        ap_i = 1'b0;
    logic        dqm_i = 1'b0;
    logic        rd_drive_o, err_o;
    logic [11:0] bank_state_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sdram_bank_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
        .ap_i(ap_i), .dqm_i(dqm_i), .rd_drive_o(rd_drive_o),
        .err_o(err_o), .bank_state_o(bank_state_o)
    );

    // {req, cmd, bank, ap, dqm, exp_drive, exp_err, exp_s0, exp_s1}
    function automatic logic [18:0] mk(input logic [3:0] r, input logic [2:0] c,
                                       input logic [1:0] b, input logic a, input logic d,
                                       input logic dv, input logic e,
                                       input logic [2:0] s0, input logic [2:0] s1);
        return {r, c, b, a, d, dv, e, s0, s1};
    endfunction

    localparam int NV = 43;
    localparam logic [18:0] VEC [NV] = '{
        // R2 open two banks
        mk(2, 1, 0, 0, 0, 0, 0, 1, 0),
        mk(2, 1, 1, 0, 0, 0, 0, 1, 1),
        // R4 read with auto-precharge on bank 0, no data yet
        mk(4, 2, 0, 1, 0, 0, 0, 2, 1),
        mk(4, 0, 0, 0, 0, 0, 0, 2, 1),
        // R5 read to bank 1 interrupts; bank 0 precharges now, first beat shows
        mk(5, 2, 1, 0, 0, 1, 0, 5, 2),
        mk(5, 0, 0, 0, 0, 1, 0, 5, 2),
        mk(5, 0, 0, 0, 0, 1, 0, 5, 2),
        // R5 ACTIVATE TRP clocks after the interrupting read is accepted
        mk(5, 1, 0, 0, 0, 1, 0, 1, 2),
        // R3 bank 1 burst without auto-precharge returns to ACTIVE
        mk(3, 0, 0, 0, 0, 1, 0, 1, 1),
        // R12 DESELECT changes nothing
        mk(12, 7, 3, 0, 0, 1, 0, 1, 1),
        mk(4, 0, 0, 0, 0, 0, 0, 1, 1),
        // R6 read-ap bank 0, DQM two clocks before write
        mk(6, 2, 0, 1, 0, 0, 0, 2, 1),
        mk(6, 0, 0, 0, 1, 0, 0, 2, 1),
        // R7 beat masked by DQM
        mk(7, 0, 0, 0, 0, 0, 0, 2, 1),
        // R6 write-ap to bank 1 interrupts, no collision, bank 0 precharges
        mk(6, 3, 1, 1, 0, 0, 0, 5, 3),
        // R9 write-ap chain
        mk(9, 0, 0, 0, 0, 0, 0, 5, 3),
        mk(9, 0, 0, 0, 0, 0, 0, 5, 3),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 3),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 4),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 4),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 5),
        mk(12, 7, 0, 0, 0, 0, 0, 0, 5),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 5),
        mk(9, 0, 0, 0, 0, 0, 0, 0, 0),
        // R2 reopen
        mk(2, 1, 0, 0, 0, 0, 0, 1, 0),
        mk(2, 1, 1, 0, 0, 0, 0, 1, 1),
        // R4 plain read, then R8 write with DQM low
        mk(4, 2, 0, 0, 0, 0, 0, 2, 1),
        mk(4, 0, 0, 0, 0, 0, 0, 2, 1),
        mk(4, 0, 0, 0, 0, 1, 0, 2, 1),
        mk(8, 3, 1, 0, 0, 0, 1, 1, 3),
        mk(3, 0, 0, 0, 0, 0, 0, 1, 3),
        mk(3, 0, 0, 0, 0, 0, 0, 1, 3),
        mk(3, 0, 0, 0, 0, 0, 0, 1, 3),
        mk(3, 0, 0, 0, 0, 0, 0, 1, 1),
        // R10 read to idle bank 2: error, no beats later
        mk(10, 2, 2, 0, 0, 0, 1, 1, 1),
        mk(10, 0, 0, 0, 0, 0, 0, 1, 1),
        mk(10, 0, 0, 0, 0, 0, 0, 1, 1),
        mk(10, 0, 0, 0, 0, 0, 0, 1, 1),
        // R11 ACTIVATE to open bank
        mk(11, 1, 0, 0, 0, 0, 1, 1, 1),
        mk(2, 4, 0, 0, 0, 0, 0, 5, 1),
        // R11 ACTIVATE too early in precharge
        mk(11, 1, 0, 0, 0, 0, 1, 5, 1),
        mk(2, 0, 0, 0, 0, 0, 0, 5, 1),
        mk(2, 1, 0, 0, 0, 0, 0, 1, 1)
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset state", {20'd0, bank_state_o}, 32'd0);
        check("R1 reset drive/err", {30'd0, rd_drive_o, err_o}, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [18:0] v;
            v = VEC[k];
            @(negedge clk);
            cmd_i = v[14:12]; bank_i = v[11:10]; ap_i = v[9]; dqm_i = v[8];
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec%0d", v[18:15], k),
                  {26'd0, rd_drive_o, err_o, bank_state_o[2:0], bank_state_o[5:3]},
                  {26'd0, v[7:0]});
        end

        @(negedge clk);
        cmd_i = 3'd0;
        // R10 bank 2 and 3 untouched by ignored read
        check("R10 bank2/3 idle", {26'd0, bank_state_o[11:6]}, 32'd0);

        // R1 mid-run reset
        cmd_i = 3'd1; bank_i = 2'd3;
        @(negedge clk);
        cmd_i = 3'd0;
        check("R2 bank3 active", {29'd0, bank_state_o[11:9]}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears banks", {20'd0, bank_state_o}, 32'd0);
        rst_n = 1'b1;

        // R12 unused code 5 acts as NOP
        cmd_i = 3'd5; bank_i = 2'd0;
        @(negedge clk);
        cmd_i = 3'd0;
        check("R12 unused code", {19'd0, err_o, bank_state_o}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule